// File: doc/BRIEF.md
# Bus-Master DMA Control Registers for a Two-Channel Disk Controller

This block holds the per-channel control and status state that software uses to launch and supervise bus-master DMA transfers on a two-channel disk interface. Each channel has a command byte, a status byte and a 32-bit descriptor-table pointer. All of them sit in one byte-addressed register window. The registers for channel `c` start at byte `8*c`.

A write that sets the command start bit launches a transfer on the device currently selected for that channel. The block sends a one-cycle start pulse, together with the stored pointer, to an external DMA engine. A write that clears the start bit sends a one-cycle abort pulse instead. When the engine finishes, it returns a one-cycle completion pulse. The block then retires the transfer and raises the channel's interrupt, which stays high until software clears it.

The device-select byte is written through a separate strobe, because the drive register file lives outside this block. Bit 4 of that byte picks device 1 (set) or device 0 (clear) as the target of later starts. All pins are plain control and status signals with no back-pressure. A write is taken in the cycle its strobe is high, and every pulse output lasts exactly one cycle.

Top module: `bmdma_regs`

## Requirements
- R1: A legal command write (byte offset 0, bit 0 = start, bit 3 = direction) that moves start from 0 to 1 while the selected device is present does three things one cycle after the write edge: it sets status bit 0 (active), pulses `dma_start` for that channel, and presents the stored pointer on `dma_ptr`.
- R2: A legal command write that moves start from 1 to 0 clears the active bit and pulses `dma_abort` for exactly one cycle. A single cycle never carries both a start and an abort pulse.
- R3: A 0-to-1 start write whose selected device is absent (`dev_present` bit `2c+sel` low) does four things: it pulses `start_err`, sets status bit 1 (error), issues no start, and leaves the command byte unchanged.
- R4: Software writes to the status byte (offset 2) never change the active bit. The active bit changes only through a start pulse, an abort pulse or a completion.
- R5: Status bit 2 (interrupt) and status bit 1 (error) are cleared by writing 1 and left unchanged by writing 0.
- R6: Status bits 5 and 6 (device 0 and device 1 DMA-capable) always read 1. Reserved bits, and the reserved bytes at offsets 1 and 3, read 0.
- R7: A `dma_done` pulse clears the start bit and the active bit and sets the interrupt bit, all at the next edge. This completion wins over a command write to the same channel in the same cycle. Each `irq` output is the level of its channel's interrupt bit.
- R8: Writes are legal only in these forms: a 1-byte write to offset 0 or 2, or a 4-byte write to offset 4. `reg_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal. Any other write pulses `acc_err` for one cycle and changes no register.
- R9: A pointer write stores `reg_wdata` with bits 1:0 forced to 0. Reads return the little-endian bytes of the channel block starting at the addressed byte.
- R10: Channel 1's command, status and pointer sit at bytes 8, 10 and 12. A write to one channel never alters the other channel's registers.
- R11: A `drv_sel_wr` strobe for a channel loads bit 4 of `drv_sel_data` as that channel's selected device. `dma_dev` shows the selected device, and the presence check of R3 uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Byte address in the register window |
| reg_size | input | 2 | Write size code (0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = illegal) |
| reg_wdata | input | 32 | Write data, little-endian from the addressed byte |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| acc_err | output | 1 | One-cycle pulse on an illegal write |
| drv_sel_wr | input | NCH | Per-channel device-select write strobe |
| drv_sel_data | input | 8 | Device-select byte (bit 4 = device 1) |
| dev_present | input | 2*NCH | Device presence, bit `2c+d` for device `d` of channel `c` |
| dma_done | input | NCH | Per-channel completion pulse |
| dma_start | output | NCH | Per-channel start pulse |
| dma_abort | output | NCH | Per-channel abort pulse |
| dma_dev | output | NCH | Selected device per channel |
| dma_ptr | output | 32*NCH | Descriptor pointer per channel |
| start_err | output | NCH | Pulse when a start targets an absent device |
| irq | output | NCH | Per-channel interrupt level |

## Verification
A corrupted start bit shows up in two places. The command-byte readback is wrong on the very next read, and the next write then produces the wrong edge: a spurious or missing start or abort pulse one cycle after that write. A stuck or wrong active, error or interrupt bit is seen in the status readback and, for the interrupt, on `irq` one cycle after the event that should have moved it. The pointer and the device selection stay hidden until a start: a wrong pointer appears on `dma_ptr` in the start cycle, and a wrong selection appears as a wrong `start_err` decision.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int BLK_BYTES = 8;
  localparam logic [2:0] OFF_CMD = 3'd0;
  localparam logic [2:0] OFF_STS = 3'd2;
  localparam logic [2:0] OFF_PTR = 3'd4;

  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 3;
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_INT  = 2;
  localparam int ST_CAP0 = 5;
  localparam int ST_CAP1 = 6;
  localparam int SEL_BIT = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input  logic [AW-1:0]  addr,
  input  logic [1:0]     size,
  input  logic           wr,
  output logic [NCH-1:0] cmd_we,
  output logic [NCH-1:0] sts_we,
  output logic [NCH-1:0] ptr_we,
  output logic           bad
);
  localparam int CW = AW - 3;

  logic [CW-1:0] ch;
  logic [2:0]    off;
  logic          in_rng;
  logic          legal;

  assign ch  = addr[AW-1:3];
  assign off = addr[2:0];

  always_comb begin
    in_rng = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (ch == CW'(c)) in_rng = 1'b1;
    end
    legal = in_rng &&
            ((((off == OFF_CMD) || (off == OFF_STS)) && (size == SZ_BYTE)) ||
             ((off == OFF_PTR) && (size == SZ_WORD)));
  end

  always_comb begin
    cmd_we = '0;
    sts_we = '0;
    ptr_we = '0;
    bad    = 1'b0;
    if (wr) begin
      if (!legal) begin
        bad = 1'b1;
      end else begin
        for (int c = 0; c < NCH; c++) begin
          if (ch == CW'(c)) begin
            cmd_we[c] = (off == OFF_CMD);
            sts_we[c] = (off == OFF_STS);
            ptr_we[c] = (off == OFF_PTR);
          end
        end
      end
    end
  end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic        sts_we,
  input  logic        ptr_we,
  input  logic [31:0] wdata,
  input  logic        sel_we,
  input  logic [7:0]  sel_byte,
  input  logic [1:0]  present,
  input  logic        done,
  output logic [7:0]  cmd_q,
  output logic [7:0]  sts_q,
  output logic [31:0] ptr_q,
  output logic        dev_q,
  output logic        start_p,
  output logic        abort_p,
  output logic        nodev_p,
  output logic        irq
);
  logic go_q, dir_q, act_q, err_q, int_q;
  logic rise, fall, dev_ok;

  assign rise   = cmd_we && !go_q && wdata[CMD_GO];
  assign fall   = cmd_we && go_q && !wdata[CMD_GO];
  assign dev_ok = present[dev_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      dir_q   <= 1'b0;
      act_q   <= 1'b0;
      err_q   <= 1'b0;
      int_q   <= 1'b0;
      ptr_q   <= '0;
      dev_q   <= 1'b0;
      start_p <= 1'b0;
      abort_p <= 1'b0;
      nodev_p <= 1'b0;
    end else begin
      start_p <= 1'b0;
      abort_p <= 1'b0;
      nodev_p <= 1'b0;
      if (cmd_we) begin
        if (rise && !dev_ok) begin
          nodev_p <= 1'b1;
          err_q   <= 1'b1;
        end else begin
          go_q  <= wdata[CMD_GO];
          dir_q <= wdata[CMD_DIR];
          if (rise && !done) begin
            act_q   <= 1'b1;
            start_p <= 1'b1;
          end
          if (fall) begin
            act_q   <= 1'b0;
            abort_p <= 1'b1;
          end
        end
      end
      if (sts_we) begin
        if (wdata[ST_ERR]) err_q <= 1'b0;
        if (wdata[ST_INT]) int_q <= 1'b0;
      end
      if (ptr_we) ptr_q <= {wdata[31:2], 2'b00};
      if (sel_we) dev_q <= sel_byte[SEL_BIT];
      if (done) begin
        go_q  <= 1'b0;
        act_q <= 1'b0;
        int_q <= 1'b1;
      end
    end
  end

  always_comb begin
    cmd_q           = '0;
    cmd_q[CMD_GO]   = go_q;
    cmd_q[CMD_DIR]  = dir_q;
    sts_q           = '0;
    sts_q[ST_ACT]   = act_q;
    sts_q[ST_ERR]   = err_q;
    sts_q[ST_INT]   = int_q;
    sts_q[ST_CAP0]  = 1'b1;
    sts_q[ST_CAP1]  = 1'b1;
  end

  assign irq = int_q;
endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input  logic [AW-1:0]            addr,
  input  logic [NCH-1:0][7:0]      cmd_vec,
  input  logic [NCH-1:0][7:0]      sts_vec,
  input  logic [NCH-1:0][31:0]     ptr_vec,
  output logic [31:0]              rdata
);
  localparam int CW = AW - 3;

  logic [63:0] blk;
  logic [5:0]  sh;

  assign sh = {addr[2:0], 3'b000};

  always_comb begin
    blk = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr[AW-1:3] == CW'(c)) begin
        blk = {ptr_vec[c], 8'h00, sts_vec[c], 8'h00, cmd_vec[c]};
      end
    end
    rdata = blk[31:0];
    rdata = 32'(blk >> sh);
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = $clog2(NCH * BLK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic [1:0]        reg_size,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_wr,
  output logic [31:0]       reg_rdata,
  output logic              acc_err,
  input  logic [NCH-1:0]    drv_sel_wr,
  input  logic [7:0]        drv_sel_data,
  input  logic [2*NCH-1:0]  dev_present,
  input  logic [NCH-1:0]    dma_done,
  output logic [NCH-1:0]    dma_start,
  output logic [NCH-1:0]    dma_abort,
  output logic [NCH-1:0]    dma_dev,
  output logic [32*NCH-1:0] dma_ptr,
  output logic [NCH-1:0]    start_err,
  output logic [NCH-1:0]    irq
);
  logic [NCH-1:0]        cmd_we, sts_we, ptr_we;
  logic                  bad;
  logic [NCH-1:0][7:0]   cmd_vec, sts_vec;
  logic [NCH-1:0][31:0]  ptr_vec;

  bmdma_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .addr(reg_addr), .size(reg_size), .wr(reg_wr),
    .cmd_we(cmd_we), .sts_we(sts_we), .ptr_we(ptr_we), .bad(bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_err <= 1'b0;
    else        acc_err <= bad;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bmdma_chan u_ch (
      .clk(clk), .rst_n(rst_n),
      .cmd_we(cmd_we[c]), .sts_we(sts_we[c]), .ptr_we(ptr_we[c]),
      .wdata(reg_wdata),
      .sel_we(drv_sel_wr[c]), .sel_byte(drv_sel_data),
      .present(dev_present[2*c+1:2*c]),
      .done(dma_done[c]),
      .cmd_q(cmd_vec[c]), .sts_q(sts_vec[c]), .ptr_q(ptr_vec[c]),
      .dev_q(dma_dev[c]),
      .start_p(dma_start[c]), .abort_p(dma_abort[c]), .nodev_p(start_err[c]),
      .irq(irq[c])
    );
    assign dma_ptr[32*c +: 32] = ptr_vec[c];
  end

  bmdma_rdmux #(.NCH(NCH), .AW(AW)) u_rd (
    .addr(reg_addr), .cmd_vec(cmd_vec), .sts_vec(sts_vec),
    .ptr_vec(ptr_vec), .rdata(reg_rdata)
  );
endmodule

// File: rtl/bmdma_chk.sv
module bmdma_chk #(
  parameter int NCH = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCH-1:0]      dma_start,
  input logic [NCH-1:0]      dma_abort,
  input logic [NCH-1:0]      start_err,
  input logic [NCH-1:0]      dma_done,
  input logic [NCH-1:0]      irq,
  input logic [NCH-1:0][7:0] sts_vec
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start[c] |-> sts_vec[c][0]); // R1
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_abort[c] |-> (!sts_vec[c][0] && !dma_start[c])); // R2
    AST_NODEV_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_err[c] |-> (!dma_start[c] && sts_vec[c][1])); // R3
    AST_ACTIVE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sts_vec[c][0]) |-> (dma_start[c] || dma_abort[c] || $past(dma_done[c]))); // R4
    AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done[c] |=> (irq[c] && !sts_vec[c][0])); // R7
  end
endmodule

bind bmdma_regs bmdma_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_start(dma_start), .dma_abort(dma_abort),
  .start_err(start_err), .dma_done(dma_done), .irq(irq), .sts_vec(sts_vec)
);

// File: tb/test_bmdma_regs.sv
`timescale 1ns/1ps
module test_bmdma_regs;
  localparam int NCH = 2;
  localparam int AW  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [AW-1:0]     reg_addr = '0;
  logic [1:0]        reg_size = '0;
  logic [31:0]       reg_wdata = '0;
  logic              reg_wr = 1'b0;
  logic [31:0]       reg_rdata;
  logic              acc_err;
  logic [NCH-1:0]    drv_sel_wr = '0;
  logic [7:0]        drv_sel_data = '0;
  logic [2*NCH-1:0]  dev_present = '1;
  logic [NCH-1:0]    dma_done = '0;
  logic [NCH-1:0]    dma_start, dma_abort, dma_dev, start_err, irq;
  logic [32*NCH-1:0] dma_ptr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit       m_go[NCH], m_dir[NCH], m_act[NCH], m_err[NCH], m_int[NCH], m_dev[NCH];
  bit [31:0] m_ptr[NCH];
  bit [NCH-1:0] e_start, e_abort, e_nodev;
  bit           e_acc;

  always #2 clk = ~clk;

  bmdma_regs #(.NCH(NCH)) i_bmdma_regs (.*);

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit [7:0] exp_cmd(int c);
    return {4'b0, m_dir[c], 2'b0, m_go[c]};
  endfunction

  function automatic bit [7:0] exp_sts(int c);
    return {1'b0, 2'b11, 2'b00, m_int[c], m_err[c], m_act[c]};
  endfunction

  task automatic read_all();
    for (int c = 0; c < NCH; c++) begin
      reg_addr = AW'(c*8);     #0.2;
      chk(reg_rdata[7:0] == exp_cmd(c), "R1", "cmd readback", reg_rdata[7:0], exp_cmd(c));
      reg_addr = AW'(c*8 + 1); #0.2;
      chk(reg_rdata[7:0] == 8'h00, "R6", "reserved byte", reg_rdata[7:0], 0);
      reg_addr = AW'(c*8 + 2); #0.2;
      chk(reg_rdata[7:0] == exp_sts(c), "R5", "status readback", reg_rdata[7:0], exp_sts(c));
      reg_addr = AW'(c*8 + 4); #0.2;
      chk(reg_rdata == m_ptr[c], "R9", "pointer readback", reg_rdata, m_ptr[c]);
      chk(irq[c] == m_int[c], "R7", "irq level", irq[c], m_int[c]);
      chk(dma_dev[c] == m_dev[c], "R11", "selected device", dma_dev[c], m_dev[c]);
    end
  endtask

  task automatic check_pulses();
    chk(dma_start == e_start, "R1", "dma_start", dma_start, e_start);
    chk(dma_abort == e_abort, "R2", "dma_abort", dma_abort, e_abort);
    chk(start_err == e_nodev, "R3", "start_err", start_err, e_nodev);
    chk(acc_err == e_acc, "R8", "acc_err", acc_err, e_acc);
    for (int c = 0; c < NCH; c++)
      if (e_start[c])
        chk(dma_ptr[32*c +: 32] == m_ptr[c], "R1", "dma_ptr at start", dma_ptr[32*c +: 32], m_ptr[c]);
  endtask

  task automatic do_write(int addr, int sz, bit [31:0] d);
    int c = addr >> 3;
    int off = addr & 7;
    bit legal = (c < NCH) && ((((off == 0) || (off == 2)) && sz == 0) || (off == 4 && sz == 2));
    e_start = '0; e_abort = '0; e_nodev = '0; e_acc = !legal;
    if (legal) begin
      case (off)
        0: begin
          bit rise = !m_go[c] && d[0];
          bit fall = m_go[c] && !d[0];
          if (rise && !dev_present[2*c + m_dev[c]]) begin
            e_nodev[c] = 1'b1; m_err[c] = 1'b1;
          end else begin
            m_go[c] = d[0]; m_dir[c] = d[3];
            if (rise) begin m_act[c] = 1'b1; e_start[c] = 1'b1; end
            if (fall) begin m_act[c] = 1'b0; e_abort[c] = 1'b1; end
          end
        end
        2: begin
          if (d[1]) m_err[c] = 1'b0;
          if (d[2]) m_int[c] = 1'b0;
        end
        default: m_ptr[c] = d & 32'hFFFF_FFFC;
      endcase
    end
    @(negedge clk);
    reg_addr = AW'(addr); reg_size = 2'(sz); reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    check_pulses();
    read_all();
  endtask

  task automatic do_done(int c);
    m_go[c] = 1'b0; m_act[c] = 1'b0; m_int[c] = 1'b1;
    @(negedge clk); dma_done[c] = 1'b1;
    @(posedge clk); #1; dma_done[c] = 1'b0;
    read_all();
  endtask

  task automatic do_sel(int c, bit [7:0] b);
    m_dev[c] = b[4];
    @(negedge clk); drv_sel_wr[c] = 1'b1; drv_sel_data = b;
    @(posedge clk); #1; drv_sel_wr[c] = 1'b0;
    read_all();
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int c = 0; c < NCH; c++) begin
      m_go[c] = 0; m_dir[c] = 0; m_act[c] = 0; m_err[c] = 0; m_int[c] = 0; m_dev[c] = 0; m_ptr[c] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R6: reset state and capability bits
    reg_addr = AW'(2); #0.2;
    chk(reg_rdata[7:0] == 8'h60, "R6", "status after reset", reg_rdata[7:0], 8'h60);
    read_all();

    // R9 / R10: pointer low bits and channel isolation
    do_write(4, 2, 32'hDEAD_BEEF);
    do_write(12, 2, 32'h1234_5677);
    // R8: illegal size on command and pointer
    do_write(0, 1, 32'h1);
    do_write(4, 0, 32'hFFFF_FFFF);
    do_write(2, 3, 32'h6);
    // R1 then R4: status write cannot clear active
    do_write(0, 0, 32'h9);
    do_write(2, 0, 32'hFF);
    // R7: completion, then R5 W1C (write 0 keeps, write 1 clears)
    do_done(0);
    do_write(2, 0, 32'h0);
    do_write(2, 0, 32'h4);
    // R2: start then stop on channel 1
    do_write(8, 0, 32'h1);
    do_write(8, 0, 32'h0);
    // R3 / R11: absent device 1, then select device 0
    dev_present = 4'b0101;
    do_sel(1, 8'h10);
    do_write(8, 0, 32'h1);
    do_write(10, 0, 32'h2);
    do_sel(1, 8'h00);
    do_write(8, 0, 32'h1);
    do_done(1);
    dev_present = '1;

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      int c = $urandom_range(0, NCH-1);
      if ($urandom_range(0, 15) == 0) dev_present = 4'($urandom);
      case (op)
        0, 1, 2: do_write(c*8, 0, 32'($urandom_range(0, 15)));
        3:       do_write(c*8 + 2, 0, 32'($urandom_range(0, 255)));
        4:       do_write(c*8 + 4, 2, $urandom);
        5:       do_write($urandom_range(0, 15), $urandom_range(0, 3), $urandom);
        6, 7:    do_done(c);
        default: do_sel(c, 8'($urandom));
      endcase
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule